// File: doc/BRIEF.md
# Programmable Acquisition Trigger Unit

This block decides when a waveform sampler stops recording. It takes an external TTL trigger line, four channel discriminator outputs and a software strobe, and turns them into one single-cycle stop request. The trigger lines are asynchronous, so each one passes through a two-flop synchronizer. The software strobe comes from the register interface and is synchronous.

A 16-bit configuration word sets three things: which discriminator channels count, whether they are combined by OR or by coincidence (AND), and whether the external line takes part. A polarity input chooses the active edge. A 16-bit delay value sets how many clock ticks pass between the qualified edge and the stop pulse.

Once the unit has fired, it holds off: later edges, glitches and reflections have no effect. This lasts until an arm strobe re-arms it. The arm strobe also cancels any delay count that is still running.

Top module: `acq_trigger_unit`

## Requirements
- R1: After reset, stop_o, done_o and armed_o are 0. The unit starts unarmed, so trigger-line edges cause no stop until arm_i is pulsed.
- R2: The external line takes part only when config bit 5 is 1. When that bit is 0, activity on ext_trig_i never causes a stop.
- R3: With falling_i = 0, a line becomes active on a low-to-high change. With falling_i = 1, it becomes active on a high-to-low change. The polarity applies to the external line and to all discriminator lines alike.
- R4: Let a line change so that the first rising clock edge sampling the new value is edge 1. Then stop_o is high after edge 3+D, where D is the delay value held on delay_i when the edge is qualified. With D = 0, stop_o is high after edge 3.
- R5: After a stop, done_o stays 1 and further line edges produce no stop, until arm_i is pulsed. Arming clears done_o.
- R6: When config bit 4 is 0 (OR combining), the combined trigger becomes active when any discriminator channel whose bit is set in config bits 3:0 becomes active. Channels whose mask bit is clear are ignored.
- R7: When config bit 4 is 1 (coincidence), the combined trigger becomes active only when all masked channels are active at the same time. A mask of zero never triggers from the channels.
- R8: A sw_trig_i pulse in any state other than holdoff gives stop_o high after the next clock edge, with no delay. The sw_trig_i input is ignored during holdoff.
- R9: An arm_i pulse during a delay count cancels that count. No stop follows, and the unit is armed again (armed_o = 1, done_o = 0).
- R10: A new qualified edge that occurs while a delay count is running neither restarts nor shortens the count.
- R11: stop_o is never high for two cycles in a row. Each trigger gives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm strobe. Clears holdoff and any delay in progress |
| sw_trig_i | input | 1 | Synchronous software trigger strobe |
| ext_trig_i | input | 1 | Asynchronous external trigger line |
| disc_i | input | 4 | Asynchronous discriminator outputs, one per channel |
| cfg_i | input | 16 | Bits 3:0 channel mask, bit 4 coincidence select, bit 5 external enable |
| falling_i | input | 1 | Edge polarity: 1 = high-to-low, 0 = low-to-high |
| delay_i | input | 16 | Ticks between a qualified edge and the stop pulse |
| stop_o | output | 1 | Single-cycle stop request to the sampler |
| done_o | output | 1 | Triggered and waiting to be re-armed |
| armed_o | output | 1 | Armed or counting delay |

## Verification
Three situations are hardest to reach from the ports. The first is the arm strobe landing while a delay count is in flight. The second is a retrigger that arrives during that count. The third is a trigger line that is already active when the unit is armed. The bench reaches the first two by loading a delay of ten to twenty ticks and then, a known number of cycles after the line change, either pulsing arm or toggling the line. It then watches a long window for the stop pulse. Before every table case, the lines are brought to their idle level for that case's polarity and left for several cycles before arming, so that the synchronizer contents never look like an edge.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DELAY = 2'd2,
    ST_HOLD  = 2'd3
  } trig_state_t;
endpackage

// File: rtl/trig_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous lines.
module trig_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/trig_combine.sv
// Polarity, source selection, OR/coincidence combining and leading-edge detect.
module trig_combine #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_s_i,
  input  logic [NUM_CH-1:0] disc_s_i,
  input  logic              falling_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              coinc_i,
  input  logic              ext_en_i,
  output logic              event_o
);
  logic [NUM_CH-1:0] ch_act;
  logic              ext_act;
  logic              ch_any;
  logic              ch_all;
  logic              ch_lvl;
  logic              lvl;
  logic              lvl_q;

  assign ch_act  = disc_s_i ^ {NUM_CH{falling_i}};
  assign ext_act = ext_s_i ^ falling_i;
  assign ch_any  = |(ch_act & mask_i);
  assign ch_all  = &(ch_act | ~mask_i);

  always_comb begin
    if (mask_i == '0)  ch_lvl = 1'b0;
    else if (coinc_i)  ch_lvl = ch_all;
    else               ch_lvl = ch_any;
  end

  assign lvl = ch_lvl | (ext_en_i & ext_act);

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign event_o = lvl & ~lvl_q;
endmodule

// File: rtl/trig_seq.sv
// Arming, delay counting and holdoff sequencer.
module trig_seq
  import trig_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             sw_trig_i,
  input  logic             event_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             stop_o,
  output logic             done_o,
  output logic             armed_o
);
  trig_state_t      state;
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      stop_o <= 1'b0;
    end else begin
      stop_o <= 1'b0;
      if (arm_i) begin
        state <= ST_ARMED;
        cnt   <= '0;
      end else if (sw_trig_i && state != ST_HOLD) begin
        stop_o <= 1'b1;
        state  <= ST_HOLD;
        cnt    <= '0;
      end else begin
        case (state)
          ST_ARMED: begin
            if (event_i) begin
              if (delay_i == '0) begin
                stop_o <= 1'b1;
                state  <= ST_HOLD;
              end else begin
                cnt   <= delay_i;
                state <= ST_DELAY;
              end
            end
          end
          ST_DELAY: begin
            if (cnt == DLY_W'(1)) begin
              stop_o <= 1'b1;
              state  <= ST_HOLD;
              cnt    <= '0;
            end else begin
              cnt <= cnt - DLY_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign done_o  = (state == ST_HOLD);
  assign armed_o = (state == ST_ARMED) || (state == ST_DELAY);
endmodule

// File: rtl/acq_trigger_unit.sv
module acq_trigger_unit #(
  parameter int NUM_CH      = 4,
  parameter int CFG_W       = 16,
  parameter int DLY_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_i,
  input  logic              sw_trig_i,
  input  logic              ext_trig_i,
  input  logic [NUM_CH-1:0] disc_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              falling_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic              stop_o,
  output logic              done_o,
  output logic              armed_o
);
  localparam int COINC_BIT = NUM_CH;
  localparam int EXTEN_BIT = NUM_CH + 1;
  localparam int LINES     = NUM_CH + 1;

  logic [LINES-1:0]  raw_lines;
  logic [LINES-1:0]  sync_lines;
  logic              event_w;

  assign raw_lines = {ext_trig_i, disc_i};

  trig_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_lines),
    .sync_o  (sync_lines)
  );

  trig_combine #(.NUM_CH(NUM_CH)) u_comb (
    .clk       (clk),
    .rst       (rst),
    .ext_s_i   (sync_lines[NUM_CH]),
    .disc_s_i  (sync_lines[NUM_CH-1:0]),
    .falling_i (falling_i),
    .mask_i    (cfg_i[NUM_CH-1:0]),
    .coinc_i   (cfg_i[COINC_BIT]),
    .ext_en_i  (cfg_i[EXTEN_BIT]),
    .event_o   (event_w)
  );

  trig_seq #(.DLY_W(DLY_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .arm_i     (arm_i),
    .sw_trig_i (sw_trig_i),
    .event_i   (event_w),
    .delay_i   (delay_i),
    .stop_o    (stop_o),
    .done_o    (done_o),
    .armed_o   (armed_o)
  );
endmodule

// File: rtl/trig_checker.sv
module trig_checker (
  input logic clk,
  input logic rst,
  input logic arm_i,
  input logic sw_trig_i,
  input logic stop_o,
  input logic done_o,
  input logic armed_o
);
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> !stop_o);

  assert_sw_immediate_R8: assert property (@(posedge clk) disable iff (rst)
    (sw_trig_i && !arm_i && !done_o) |=> stop_o);

  assert_holdoff_R5: assert property (@(posedge clk) disable iff (rst)
    (done_o && !arm_i) |=> (done_o && !stop_o));

  assert_arm_clears_R9: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (armed_o && !done_o && !stop_o));

  assert_stop_enters_hold_R5: assert property (@(posedge clk) disable iff (rst)
    stop_o |-> (done_o && !armed_o));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (!armed_o && !done_o && !sw_trig_i && !arm_i) |=> !stop_o);
endmodule

bind acq_trigger_unit trig_checker u_trig_checker (
  .clk       (clk),
  .rst       (rst),
  .arm_i     (arm_i),
  .sw_trig_i (sw_trig_i),
  .stop_o    (stop_o),
  .done_o    (done_o),
  .armed_o   (armed_o)
);

// File: tb/acq_trigger_unit_test.sv
`timescale 1ns/1ps
module acq_trigger_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm_i = 1'b0;
  logic        sw_trig_i = 1'b0;
  logic        ext_trig_i = 1'b0;
  logic [3:0]  disc_i = 4'b0;
  logic [15:0] cfg_i = 16'h0;
  logic        falling_i = 1'b0;
  logic [15:0] delay_i = 16'h0;
  logic        stop_o, done_o, armed_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  acq_trigger_unit uut (
    .clk(clk), .rst(rst), .arm_i(arm_i), .sw_trig_i(sw_trig_i),
    .ext_trig_i(ext_trig_i), .disc_i(disc_i), .cfg_i(cfg_i),
    .falling_i(falling_i), .delay_i(delay_i),
    .stop_o(stop_o), .done_o(done_o), .armed_o(armed_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 50000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_arm();
    @(negedge clk) arm_i = 1'b1;
    @(negedge clk) arm_i = 1'b0;
  endtask

  // Fields: cfg(16) falling(1) delay(16) ext_act(1) disc_act(4) fire(1) lat(8)
  localparam int NV = 8;
  localparam logic [46:0] VEC [NV] = '{
    {16'h0001, 1'b0, 16'd0, 1'b0, 4'b0001, 1'b1, 8'd3},  // R6 R4
    {16'h0001, 1'b0, 16'd0, 1'b0, 4'b0010, 1'b0, 8'd0},  // R6 unmasked
    {16'h0013, 1'b0, 16'd0, 1'b0, 4'b0001, 1'b0, 8'd0},  // R7 partial
    {16'h0013, 1'b0, 16'd5, 1'b0, 4'b0011, 1'b1, 8'd8},  // R7 R4
    {16'h0020, 1'b1, 16'd2, 1'b1, 4'b0000, 1'b1, 8'd5},  // R2 R3
    {16'h0000, 1'b0, 16'd0, 1'b1, 4'b0000, 1'b0, 8'd0},  // R2 disabled
    {16'h000F, 1'b1, 16'd1, 1'b0, 4'b1000, 1'b1, 8'd4},  // R3 R6
    {16'h0010, 1'b0, 16'd0, 1'b0, 4'b1111, 1'b0, 8'd0}   // R7 mask zero
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R4/R6";
      1: return "R6";
      2: return "R7";
      3: return "R7/R4";
      4: return "R2/R3";
      5: return "R2";
      6: return "R3";
      default: return "R7";
    endcase
  endfunction

  task automatic run_case(input logic [15:0] cfg, input logic fall,
                          input logic [15:0] dly, input logic ext_a,
                          input logic [3:0] disc_a, input logic fire,
                          input int lat, input string tag);
    int first = 0;
    int hi = 0;
    int win = fire ? lat + 8 : 14;
    @(negedge clk);
    cfg_i = cfg; falling_i = fall; delay_i = dly;
    ext_trig_i = fall; disc_i = {4{fall}};
    repeat (4) @(negedge clk);
    pulse_arm();
    ext_trig_i = ext_a ^ fall;
    disc_i = disc_a ^ {4{fall}};
    for (int n = 1; n <= win; n++) begin
      @(posedge clk); @(negedge clk);
      if (stop_o) begin
        if (first == 0) first = n;
        hi++;
      end
    end
    chk(hi == (fire ? 1 : 0), tag, "stop pulse count (R11)", hi, fire ? 1 : 0);
    if (fire) chk(first == lat, tag, "stop latency", first, lat);
    chk(done_o == fire, tag, "done_o after case", done_o, fire);
    ext_trig_i = fall; disc_i = {4{fall}};
  endtask

  initial begin
    int first;
    int hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(stop_o == 0 && done_o == 0 && armed_o == 0, "R1", "reset outputs",
        {stop_o, done_o, armed_o}, 0);
    // R1: unarmed unit ignores an active channel
    cfg_i = 16'h0001; disc_i = 4'b0001;
    hi = 0;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      if (stop_o) hi++;
    end
    chk(hi == 0 && done_o == 0, "R1", "stop while unarmed", hi, 0);
    disc_i = 4'b0000;

    // R8: software trigger from idle
    @(negedge clk) sw_trig_i = 1'b1;
    @(negedge clk) sw_trig_i = 1'b0;
    chk(stop_o == 1, "R8", "sw trigger from idle", stop_o, 1);
    @(negedge clk);
    chk(stop_o == 0, "R11", "stop width", stop_o, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      run_case(VEC[i][46:31], VEC[i][30], VEC[i][29:14], VEC[i][13],
               VEC[i][12:9], VEC[i][8], int'(VEC[i][7:0]), vec_tag(i));
    end

    // R5: holdoff after a stop ignores later edges
    run_case(16'h0001, 1'b0, 16'd0, 1'b0, 4'b0001, 1'b1, 3, "R5");
    hi = 0;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk) disc_i[0] = ~disc_i[0];
      @(negedge clk);
      @(negedge clk);
      if (stop_o) hi++;
    end
    chk(hi == 0, "R5", "stops during holdoff", hi, 0);
    chk(done_o == 1, "R5", "done_o held", done_o, 1);
    disc_i = 4'b0;
    pulse_arm();
    chk(done_o == 0 && armed_o == 1, "R5", "arm clears done",
        {done_o, armed_o}, 1);

    // R8: sw trigger while armed, then ignored in holdoff
    @(negedge clk) sw_trig_i = 1'b1;
    @(negedge clk) sw_trig_i = 1'b0;
    chk(stop_o == 1, "R8", "sw trigger while armed", stop_o, 1);
    @(negedge clk) sw_trig_i = 1'b1;
    @(negedge clk) sw_trig_i = 1'b0;
    chk(stop_o == 0 && done_o == 1, "R8", "sw trigger in holdoff",
        stop_o, 0);

    // R9: arm during delay cancels it
    cfg_i = 16'h0001; delay_i = 16'd20; falling_i = 1'b0; disc_i = 4'b0;
    repeat (4) @(negedge clk);
    pulse_arm();
    disc_i = 4'b0001;
    repeat (8) @(negedge clk);
    pulse_arm();
    hi = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (stop_o) hi++;
    end
    chk(hi == 0, "R9", "stop after cancel", hi, 0);
    chk(armed_o == 1 && done_o == 0, "R9", "re-armed state",
        {armed_o, done_o}, 2);

    // R10: retrigger during delay does not restart the count
    disc_i = 4'b0; delay_i = 16'd10;
    repeat (4) @(negedge clk);
    pulse_arm();
    disc_i = 4'b0001;
    first = 0; hi = 0;
    for (int n = 1; n <= 24; n++) begin
      @(posedge clk); @(negedge clk);
      if (n == 5) disc_i = 4'b0000;
      if (n == 7) disc_i = 4'b0001;
      if (stop_o) begin
        if (first == 0) first = n;
        hi++;
      end
    end
    chk(first == 13, "R10", "latency with retrigger", first, 13);
    chk(hi == 1, "R10", "pulse count with retrigger", hi, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule